// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block holds recent virtual-page to physical-page translations for 4 KB pages in 16 sets of 4 ways each. A virtual address presented on the lookup port is split into a page offset, a set index and a tag. The set index selects one set. The tag is compared against all four ways of that set in the same cycle. On a hit, the block returns the physical address, built from the cached physical page number and the untranslated offset. On a miss, it reports no hit.

Pages that share a set index can be held in different ways at the same time. A conflict therefore forces an eviction only when all four ways of the set are in use.

Translations are installed through a refill port, which an external page table walker drives after a miss. A refill becomes visible on the cycle after it is presented. A flush input drops every translation at once.

Top module: `tlb_sa`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss.
- R2: The address fields are fixed: tag in bits 63:16, set index in bits 15:12, page offset in bits 11:0. A lookup hits only when a valid way in the indexed set holds a tag equal to the address tag.
- R3: On a hit, `lk_paddr` equals the cached page number in bits 51:12 joined to the address bits 11:0. When there is no hit, `lk_paddr` is zero. `lk_hit` is low whenever `lk_valid` is low.
- R4: A refill presented with `rf_valid` is captured at the next rising edge. From then on, a lookup of any address in that page hits and returns the refilled page number.
- R5: Two pages with the same set index and different tags can be resident together. After addresses 0x11234 and 0x21234 are both refilled, lookups of both hit.
- R6: A refill with no matching tag writes the lowest-numbered invalid way of its set. As a result, four refills into an empty set fill ways 0, 1, 2 and 3 in order.
- R7: When all four ways of a set are valid and the refill tag is new, the refill replaces the way chosen by that set's round-robin pointer. The pointer starts at way 0 after reset and advances by one, wrapping after way 3, on each such replacement.
- R8: Each set has its own replacement pointer. Replacements in one set do not move the pointer of another set.
- R9: A refill whose tag matches a valid way of its set overwrites that way. It creates no second copy, and the lookup returns only the new page number.
- R10: A flush clears every valid bit at the next rising edge. A refill in the same cycle as a flush is discarded.
- R11: When a lookup and a refill address the same set in the same cycle, the lookup sees the contents from before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 64 | Virtual address to translate |
| lk_hit | output | 1 | Translation found (combinational, same cycle) |
| lk_paddr | output | 52 | Translated physical address, zero on miss |
| rf_valid | input | 1 | Refill request from the walker |
| rf_vaddr | input | 64 | Virtual address of the page being installed |
| rf_ppn | input | 40 | Physical page number to install |
| flush | input | 1 | Invalidate all entries |

## Verification
Most wrong internal states appear at the lookup port only later, and only for the right address. A wrong victim way or a stalled replacement pointer stays hidden until the next refill into the same full set. That refill then evicts the wrong page, and a lookup of a page that should still be resident misses. The bench therefore fills sets past capacity and probes every resident tag after each eviction. A duplicated tag appears on the very next lookup, because two page numbers merge on the output. A missed flush appears on the first lookup after the flush.

// File: rtl/tlb_sa.sv
module tlb_sa #(
  parameter int VA_W  = 64,
  parameter int PA_W  = 52,
  parameter int OFF_W = 12,
  parameter int SETS  = 16,
  parameter int WAYS  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  input  logic [VA_W-1:0]      lk_vaddr,
  output logic                 lk_hit,
  output logic [PA_W-1:0]      lk_paddr,
  input  logic                 rf_valid,
  input  logic [VA_W-1:0]      rf_vaddr,
  input  logic [PA_W-OFF_W-1:0] rf_ppn,
  input  logic                 flush
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = VA_W - OFF_W - SET_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];
  logic [WAY_W-1:0] rr_q  [SETS];

  logic [SET_W-1:0] lk_set, rf_set;
  logic [TAG_W-1:0] lk_tag, rf_tag;
  assign lk_set = lk_vaddr[OFF_W +: SET_W];
  assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];
  assign rf_set = rf_vaddr[OFF_W +: SET_W];
  assign rf_tag = rf_vaddr[VA_W-1 -: TAG_W];

  // lookup: parallel compare across the ways of one set
  logic [WAYS-1:0]  lk_match;
  logic [PPN_W-1:0] lk_ppn;
  always_comb begin
    lk_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      lk_match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      lk_ppn      = lk_ppn | ({PPN_W{lk_match[w]}} & ppn_q[lk_set][w]);
    end
  end

  assign lk_hit   = lk_valid && (|lk_match);
  assign lk_paddr = lk_hit ? {lk_ppn, lk_vaddr[OFF_W-1:0]} : '0;

  // refill victim: matching way, else lowest free way, else round robin
  logic [WAYS-1:0]  rf_match;
  logic [WAY_W-1:0] hit_way, free_way, victim;
  logic             use_rr;
  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      rf_match[w] = vld_q[rf_set][w] && (tag_q[rf_set][w] == rf_tag);
      if (rf_match[w])         hit_way  = WAY_W'(w);
      if (!vld_q[rf_set][w])   free_way = WAY_W'(w);
    end
    use_rr = !(|rf_match) && (&vld_q[rf_set]);
    if (|rf_match)  victim = hit_way;
    else if (use_rr) victim = rr_q[rf_set];
    else            victim = free_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (rf_valid) begin
      vld_q[rf_set][victim] <= 1'b1;
      if (use_rr) rr_q[rf_set] <= WAY_W'(rr_q[rf_set] + 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (rf_valid && !flush) begin
      tag_q[rf_set][victim] <= rf_tag;
      ppn_q[rf_set][victim] <= rf_ppn;
    end
  end

  // checking support
  logic [SET_W-1:0] chk_set;
  logic [TAG_W-1:0] chk_tag;
  logic [PPN_W-1:0] chk_ppn;
  logic             chk_present, any_vld;
  always_ff @(posedge clk) begin
    chk_set <= rf_set;
    chk_tag <= rf_tag;
    chk_ppn <= rf_ppn;
  end
  always_comb begin
    chk_present = 1'b0;
    any_vld     = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (vld_q[chk_set][w] && tag_q[chk_set][w] == chk_tag && ppn_q[chk_set][w] == chk_ppn)
        chk_present = 1'b1;
    for (int s = 0; s < SETS; s++) any_vld = any_vld | (|vld_q[s]);
  end

  AST_REFILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && !flush) |=> chk_present) else $error("refill not resident");   // R4
  AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)) else $error("tag resident in two ways");                // R9
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0])) else $error("offset altered"); // R3
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit) else $error("hit without request");                  // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !any_vld) else $error("entries survive flush");                   // R10
endmodule

// File: tb/sim_tlb_sa.sv
module sim_tlb_sa;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        lk_valid = 0;
  logic [63:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [51:0] lk_paddr;
  logic        rf_valid = 0;
  logic [63:0] rf_vaddr = '0;
  logic [39:0] rf_ppn = '0;
  logic        flush = 0;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tlb_sa u0 (.clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
             .lk_hit(lk_hit), .lk_paddr(lk_paddr), .rf_valid(rf_valid),
             .rf_vaddr(rf_vaddr), .rf_ppn(rf_ppn), .flush(flush));

  function automatic logic [63:0] va(input logic [47:0] tag, input logic [3:0] set);
    return {tag, set, 12'h234};
  endfunction

  task automatic check(input string req, input logic h, input logic [51:0] pa,
                       input logic eh, input logic [51:0] epa);
    compared++;
    if (h !== eh || pa !== epa) begin
      mismatched++;
      $display("FAIL %s: hit=%0b paddr=%h expected hit=%0b paddr=%h", req, h, pa, eh, epa);
    end
  endtask

  task automatic look(input string req, input logic [63:0] a, input logic eh, input logic [39:0] ep);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = a;
    #1 check(req, lk_hit, lk_paddr, eh, eh ? {ep, a[11:0]} : 52'h0);
    lk_valid = 0;
  endtask

  task automatic fill(input logic [63:0] a, input logic [39:0] p);
    @(negedge clk);
    rf_valid = 1; rf_vaddr = a; rf_ppn = p;
    @(posedge clk); #1 rf_valid = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(posedge clk); #1 flush = 0;
  endtask

  task automatic t_reset();
    look("R1", va(48'h1, 4'h1), 0, '0);
    look("R1", va(48'h0, 4'h0), 0, '0);
    @(negedge clk); lk_valid = 0; lk_vaddr = va(48'h1, 4'h1);
    #1 check("R3", lk_hit, lk_paddr, 0, '0);
  endtask

  task automatic t_basic();
    fill(64'h11234, 40'h44);
    look("R4", 64'h11234, 1, 40'h44);
    look("R3", 64'h11fff, 1, 40'h44);
    look("R2", 64'h12234, 0, '0);
    look("R2", 64'h1011234, 0, '0);
    fill(64'h21234, 40'h66);
    look("R5", 64'h11234, 1, 40'h44);
    look("R5", 64'h21234, 1, 40'h66);
    @(negedge clk); lk_valid = 1; lk_vaddr = 64'h11234;
    #1 check("R3", lk_hit, lk_paddr, 1, 52'h44234);
    lk_valid = 0;
  endtask

  task automatic t_replace();
    do_flush();
    for (int t = 1; t <= 4; t++) fill(va(48'(t), 4'h3), 40'(t + 'h100));
    for (int t = 1; t <= 4; t++) look("R6", va(48'(t), 4'h3), 1, 40'(t + 'h100));
    fill(va(48'h5, 4'h3), 40'h105);
    look("R7", va(48'h1, 4'h3), 0, '0);
    look("R7", va(48'h2, 4'h3), 1, 40'h102);
    look("R7", va(48'h5, 4'h3), 1, 40'h105);
    fill(va(48'h6, 4'h3), 40'h106);
    look("R7", va(48'h2, 4'h3), 0, '0);
    look("R7", va(48'h3, 4'h3), 1, 40'h103);
    fill(va(48'h7, 4'h3), 40'h107);
    fill(va(48'h8, 4'h3), 40'h108);
    fill(va(48'h9, 4'h3), 40'h109);
    look("R7", va(48'h5, 4'h3), 0, '0);
    look("R7", va(48'h6, 4'h3), 1, 40'h106);
    for (int t = 1; t <= 5; t++) fill(va(48'(t), 4'h7), 40'(t + 'h200));
    look("R8", va(48'h1, 4'h7), 0, '0);
    look("R8", va(48'h2, 4'h7), 1, 40'h202);
  endtask

  task automatic t_overwrite();
    do_flush();
    fill(va(48'hA, 4'h5), 40'h0F);
    fill(va(48'hA, 4'h5), 40'hF0);
    look("R9", va(48'hA, 4'h5), 1, 40'hF0);
    fill(va(48'hB, 4'h5), 40'h1);
    fill(va(48'hC, 4'h5), 40'h2);
    fill(va(48'hD, 4'h5), 40'h3);
    look("R9", va(48'hA, 4'h5), 1, 40'hF0);
    look("R9", va(48'hB, 4'h5), 1, 40'h1);
    fill(va(48'hE, 4'h5), 40'h4);
    look("R9", va(48'hA, 4'h5), 0, '0);
    look("R9", va(48'hD, 4'h5), 1, 40'h3);
  endtask

  task automatic t_flush_same();
    fill(va(48'h3, 4'h9), 40'h77);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va(48'h4, 4'h9);
    rf_valid = 1; rf_vaddr = va(48'h4, 4'h9); rf_ppn = 40'h88;
    #1 check("R11", lk_hit, lk_paddr, 0, '0);
    @(posedge clk); #1 rf_valid = 0; lk_valid = 0;
    look("R11", va(48'h4, 4'h9), 1, 40'h88);
    do_flush();
    look("R10", va(48'h3, 4'h9), 0, '0);
    look("R10", va(48'h4, 4'h9), 0, '0);
    @(negedge clk);
    flush = 1; rf_valid = 1; rf_vaddr = va(48'h6, 4'h9); rf_ppn = 40'h99;
    @(posedge clk); #1 flush = 0; rf_valid = 0;
    look("R10", va(48'h6, 4'h9), 0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_replace();
    t_overwrite();
    t_flush_same();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule